// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Configuration

This block is a watchdog timer built around a free-running event counter. Software configures it through one 32-bit configuration word. A write to that word only lands when it is the second half of a two-write unlock sequence. The watchdog counts pulses on a tick input, which stands in for the selected slow clock. It requests a reset when the count reaches a software-chosen power of two. In windowed operation it also requests a reset when software services it too early, while the count is still below a second chosen power of two.

A mode bit sends either kind of violation to an interrupt output instead of the reset output. A sealing bit, once written, freezes the configuration until the block's own reset. The clock-source choice is brought out as a select line for the oscillator mux that sits outside this block.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After reset, `rd_data` reads 0x00010080 (tick enable at bit 16 and the calibration flag at bit 7 set, everything else clear), and `wdt_rst`, `wdt_irq` and `clk_src_sel` are 0.
- R2: A write updates the configuration only when `wr_data[31:24]` is 0xAA and the write just before it carried 0x55 in that byte. Any other write disarms the sequence. A 0x55 write arms it again and never changes the configuration. Bits 31:24 always read back as zero.
- R3: Field positions are: early-service threshold select at bits 22:18, clock source at bit 17, tick enable at bit 16, timeout select at bits 12:8, calibration flag at bit 7, interrupt routing at bit 4, seal at bit 3, window mode at bit 2, spare bit at bit 1 and run at bit 0. Bits 23, 15:13 and 6:5 read as zero.
- R4: The count advances by one on each cycle with `tick` high while bits 0 and 16 are both 1. It holds while bit 16 is 0. It is forced to zero while bit 0 is 0.
- R5: When a tick brings the count to 2^T (where T is bits 12:8), the count returns to zero. In the next cycle a violation output pulses high for exactly that one cycle.
- R6: With bit 2 set, a `kick` while the count is below 2^B (where B is bits 22:18) produces a violation pulse in the next cycle and clears the count.
- R7: Any other `kick` while running clears the count and produces no pulse. This includes every kick when bit 2 is 0. A kick has priority over a tick in the same cycle, so no timeout can occur in that cycle.
- R8: A violation drives `wdt_rst` when bit 4 is 0 and `wdt_irq` when bit 4 is 1, never both.
- R9: Once the configuration holds bit 3 = 1, every later keyed write is ignored until reset.
- R10: `clk_src_sel` follows bit 17. Bits 1 and 7 are stored and read back, but have no effect on counting or violations.
- R11: While bit 0 is 0, `kick` and `tick` produce no violation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_data | input | 32 | Write data; bits 31:24 carry the key byte |
| rd_data | output | 32 | Current configuration word, key byte reading zero |
| tick | input | 1 | One pulse per period of the selected watchdog clock |
| kick | input | 1 | Service (clear) strobe from software |
| wdt_rst | output | 1 | One-cycle reset request |
| wdt_irq | output | 1 | One-cycle interrupt request |
| clk_src_sel | output | 1 | Clock source select for the external oscillator mux |

## Verification
The key collision in this block is a service strobe that arrives in the same cycle as the tick that would complete the timeout period. The bench sets up this collision by counting up to exactly one below 2^T and then driving `kick` and `tick` together. It then expects no pulse, and a full 2^T further ticks before the next timeout. A second collision drives an early kick together with a tick inside the banned window, and expects a single violation. A behavioural model in the bench, compared on every clock, judges all other cycles.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

  localparam int          CFG_W     = 32;
  localparam int          SEL_W     = 5;
  localparam logic [7:0]  KEY_ARM   = 8'h55;
  localparam logic [7:0]  KEY_FIRE  = 8'hAA;
  localparam logic [31:0] CFG_RESET = 32'h0001_0080;
  localparam logic [31:0] CFG_MASK  = 32'h007F_1F9F;
  localparam int          SEAL_BIT  = 3;

  // Full-width view of the configuration word, pads included.
  typedef struct packed {
    logic [7:0]       key;
    logic             pad23;
    logic [SEL_W-1:0] ban_sel;
    logic             src_sel;
    logic             tick_en;
    logic [2:0]       pad15;
    logic [SEL_W-1:0] tmo_sel;
    logic             cal_ok;
    logic [1:0]       pad6;
    logic             irq_mode;
    logic             seal;
    logic             win_mode;
    logic             spare;
    logic             run;
  } kwd_cfg_t;

  function automatic logic [7:0] key_field(input logic [CFG_W-1:0] word);
    return word[CFG_W-1 -: 8];
  endfunction

  function automatic logic [CFG_W-1:0] cfg_clean(input logic [CFG_W-1:0] word);
    return word & CFG_MASK;
  endfunction

endpackage

// File: rtl/kwd_keygate.sv
module kwd_keygate
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_word,
  output logic             cfg_take
);

  logic             armed_q;
  logic [CFG_W-1:0] cfg_q;
  logic [7:0]       key;
  logic             key_is_arm;
  logic             key_is_fire;
  logic             sealed;

  assign key         = key_field(wr_data);
  assign key_is_arm  = wr_en && (key == KEY_ARM);
  assign key_is_fire = wr_en && (key == KEY_FIRE) && armed_q;
  assign sealed      = cfg_q[SEAL_BIT];
  assign cfg_take    = key_is_fire && !sealed;
  assign cfg_word    = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cfg_q   <= CFG_RESET;
    end else begin
      if (wr_en) armed_q <= key_is_arm;
      if (cfg_take) cfg_q <= cfg_clean(wr_data);
    end
  end

  p_sealed_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sealed |=> $stable(cfg_q));

  p_keyed_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> ($past(wr_en) && ($past(wr_data[31:24]) == KEY_FIRE)));

  p_arm_no_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[31:24] == KEY_ARM) |=> $stable(cfg_q));

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick_en,
  input  logic             win_mode,
  input  logic [SEL_W-1:0] tmo_sel,
  input  logic [SEL_W-1:0] ban_sel,
  input  logic             tick,
  input  logic             kick,
  output logic             ev_timeout,
  output logic             ev_early,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // Weight of counter bit `sel`; zero when the bit lies beyond the counter.
  function automatic logic [CNT_W-1:0] bit_weight(input logic [SEL_W-1:0] sel);
    return ONE << sel;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             in_ban;
  logic             step;
  logic             kick_live;

  assign cnt_inc    = cnt_q + ONE;
  assign in_ban     = win_mode && (cnt_q < bit_weight(ban_sel));
  assign kick_live  = run && kick;
  assign step       = run && tick_en && tick && !kick;
  assign ev_timeout = step && (cnt_inc == bit_weight(tmo_sel));
  assign ev_early   = kick_live && in_ban;
  assign cnt_o      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || kick_live || ev_timeout) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_inc;
    end
  end

  p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !kick) |=> $stable(cnt_q));

  p_kick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_live |=> (cnt_q == '0));

  p_no_dual_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_timeout && ev_early));

endmodule

// File: rtl/kwd_alarm.sv
module kwd_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic irq_mode,
  output logic rst_req,
  output logic irq_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      irq_req <= 1'b0;
    end else begin
      rst_req <= fire && !irq_mode;
      irq_req <= fire && irq_mode;
    end
  end

  p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && irq_req));

  p_route_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && irq_mode) |=> (irq_req && !rst_req));

endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        tick,
  input  logic        kick,
  output logic        wdt_rst,
  output logic        wdt_irq,
  output logic        clk_src_sel
);

  logic [CFG_W-1:0] cfg_word;
  logic             cfg_take;
  kwd_cfg_t         cfg;
  logic             ev_timeout;
  logic             ev_early;
  logic             ev_any;
  logic [CNT_W-1:0] cnt;

  kwd_keygate u_keygate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg_word (cfg_word),
    .cfg_take (cfg_take)
  );

  assign cfg = kwd_cfg_t'(cfg_word);

  kwd_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (cfg.run),
    .tick_en    (cfg.tick_en),
    .win_mode   (cfg.win_mode),
    .tmo_sel    (cfg.tmo_sel),
    .ban_sel    (cfg.ban_sel),
    .tick       (tick),
    .kick       (kick),
    .ev_timeout (ev_timeout),
    .ev_early   (ev_early),
    .cnt_o      (cnt)
  );

  assign ev_any = ev_timeout || ev_early;

  kwd_alarm u_alarm (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (ev_any),
    .irq_mode (cfg.irq_mode),
    .rst_req  (wdt_rst),
    .irq_req  (wdt_irq)
  );

  assign rd_data     = cfg;
  assign clk_src_sel = cfg.src_sel;

  p_zero_after_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_rst || wdt_irq) |-> (cnt == '0));

  p_take_is_keyed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_take |-> (wr_en && wr_data[31:24] == 8'hAA));

  p_disabled_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.run |=> !(wdt_rst || wdt_irq));

endmodule

// File: tb/keyed_window_watchdog_tb.sv
module keyed_window_watchdog_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        tick = 1'b0;
  logic        kick = 1'b0;
  logic [31:0] rd_data;
  logic        wdt_rst, wdt_irq, clk_src_sel;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // Behavioural reference state
  bit [31:0] m_cfg;
  bit        m_armed;
  longint    m_cnt;
  bit        m_rst, m_irq;

  keyed_window_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .tick(tick), .kick(kick), .wdt_rst(wdt_rst), .wdt_irq(wdt_irq),
    .clk_src_sel(clk_src_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 32'h0001_0080; m_armed = 0; m_cnt = 0; m_rst = 0; m_irq = 0;
    end else begin
      bit ev;
      int tmo, ban;
      ev = 0;
      tmo = int'(m_cfg[12:8]);
      ban = int'(m_cfg[22:18]);
      if (!m_cfg[0]) m_cnt = 0;
      else if (kick) begin
        if (m_cfg[2] && m_cnt < (longint'(1) << ban)) ev = 1;
        m_cnt = 0;
      end else if (tick && m_cfg[16]) begin
        if (m_cnt + 1 == (longint'(1) << tmo)) begin ev = 1; m_cnt = 0; end
        else m_cnt = m_cnt + 1;
      end
      m_rst = ev && !m_cfg[4];
      m_irq = ev && m_cfg[4];
      if (wr_en) begin
        if (wr_data[31:24] == 8'h55) m_armed = 1;
        else begin
          if (wr_data[31:24] == 8'hAA && m_armed && !m_cfg[3]) m_cfg = wr_data & 32'h007F_1F9F;
          m_armed = 0;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " model rd_data"}, rd_data, m_cfg);
      chk({cur_req, " model wdt_rst"}, {31'b0, wdt_rst}, {31'b0, m_rst});
      chk({cur_req, " model wdt_irq"}, {31'b0, wdt_irq}, {31'b0, m_irq});
      chk({cur_req, " model clk_src_sel"}, {31'b0, clk_src_sel}, {31'b0, m_cfg[17]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // One clock: drive at negedge, return at the next negedge.
  task automatic step(input bit w, input logic [31:0] d, input bit t, input bit k);
    wr_en = w; wr_data = d; tick = t; kick = k;
    @(negedge clk);
    wr_en = 0; wr_data = '0; tick = 0; kick = 0;
  endtask

  task automatic keyed(input logic [31:0] d);
    step(1, {8'h55, 24'h0}, 0, 0);
    step(1, {8'hAA, d[23:0]}, 0, 0);
  endtask

  // Issue n ticks; report whether any cycle after them shows a pulse.
  task automatic ticks(input int n, output bit saw_rst, output bit saw_irq);
    saw_rst = 0; saw_irq = 0;
    for (int i = 0; i < n; i++) begin
      step(0, '0, 1, 0);
      saw_rst |= wdt_rst; saw_irq |= wdt_irq;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    bit sr, si;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    chk("R1 reset rd_data", rd_data, 32'h0001_0080);
    chk("R1 reset pulses", {30'b0, wdt_rst, wdt_irq}, 32'h0);
    chk("R1 reset clk_src_sel", {31'b0, clk_src_sel}, 32'h0);

    cur_req = "R2";
    step(1, 32'hAA00_0001, 0, 0);
    chk("R2 unarmed write ignored", rd_data, 32'h0001_0080);
    step(1, 32'h5500_0001, 0, 0);
    chk("R2 arm write no change", rd_data, 32'h0001_0080);
    step(1, 32'h1200_0001, 0, 0);
    step(1, 32'hAA00_0001, 0, 0);
    chk("R2 broken sequence ignored", rd_data, 32'h0001_0080);
    step(1, 32'h5500_0000, 0, 0);
    step(1, 32'h5500_0000, 0, 0);
    step(1, 32'hAA01_0301, 0, 0);
    chk("R2 rearmed keyed write", rd_data, 32'h0001_0301);

    cur_req = "R3";
    keyed(32'hFFFF_FFF7);
    chk("R3 field layout readback", rd_data, 32'h007F_1F97);
    chk("R10 clock source follows bit17", {31'b0, clk_src_sel}, 32'h1);

    cur_req = "R5";
    keyed(32'h0001_0301);
    ticks(7, sr, si);
    chk("R5 no pulse before 2^T", {30'b0, sr, si}, 32'h0);
    step(0, '0, 1, 0);
    chk("R5 timeout pulse", {31'b0, wdt_rst}, 32'h1);
    step(0, '0, 0, 0);
    chk("R5 pulse is one cycle", {31'b0, wdt_rst}, 32'h0);
    ticks(7, sr, si);
    step(0, '0, 1, 0);
    chk("R5 counter restarted after pulse", {31'b0, wdt_rst}, 32'h1);

    cur_req = "R4";
    keyed(32'h0000_0301);
    ticks(20, sr, si);
    chk("R4 tick enable off holds count", {30'b0, sr, si}, 32'h0);
    keyed(32'h0001_0300);
    ticks(20, sr, si);
    step(0, '0, 0, 1);
    chk("R11 disabled ignores tick and kick", {30'b0, wdt_rst, wdt_irq}, 32'h0);
    keyed(32'h0009_0004);
    step(0, '0, 1, 1);
    chk("R11 disabled window kick ignored", {30'b0, wdt_rst, wdt_irq}, 32'h0);

    cur_req = "R6";
    keyed(32'h0009_0405);
    step(0, '0, 1, 0);
    step(0, '0, 0, 1);
    chk("R6 early kick violation", {31'b0, wdt_rst}, 32'h1);
    step(0, '0, 1, 1);
    chk("R6 early kick with tick single violation", {30'b0, wdt_rst, wdt_irq}, 32'h2);
    cur_req = "R7";
    ticks(4, sr, si);
    step(0, '0, 0, 1);
    chk("R7 kick after window legal", {30'b0, wdt_rst, wdt_irq}, 32'h0);
    ticks(15, sr, si);
    chk("R7 legal kick restarted count", {30'b0, sr, si}, 32'h0);
    step(0, '0, 1, 0);
    chk("R7 full period after legal kick", {31'b0, wdt_rst}, 32'h1);

    keyed(32'h0001_0201);
    step(0, '0, 0, 1);
    chk("R7 kick with window off legal", {30'b0, wdt_rst, wdt_irq}, 32'h0);
    ticks(3, sr, si);
    step(0, '0, 1, 1);
    chk("R7 kick beats final tick", {30'b0, wdt_rst, wdt_irq}, 32'h0);
    ticks(3, sr, si);
    chk("R7 no early timeout after collision", {30'b0, sr, si}, 32'h0);
    step(0, '0, 1, 0);
    chk("R7 timeout after full period", {31'b0, wdt_rst}, 32'h1);

    cur_req = "R8";
    keyed(32'h0001_0211);
    ticks(3, sr, si);
    step(0, '0, 1, 0);
    chk("R8 interrupt routing", {30'b0, wdt_rst, wdt_irq}, 32'h1);

    cur_req = "R10";
    keyed(32'h0001_0383);
    ticks(7, sr, si);
    chk("R10 spare/cal bits no effect early", {30'b0, sr, si}, 32'h0);
    step(0, '0, 1, 0);
    chk("R10 spare/cal bits no effect timeout", {31'b0, wdt_rst}, 32'h1);

    cur_req = "R9";
    keyed(32'h0001_0109);
    chk("R9 seal write applied", rd_data, 32'h0001_0109);
    keyed(32'h0000_0000);
    chk("R9 sealed write ignored", rd_data, 32'h0001_0109);
    ticks(1, sr, si);
    step(0, '0, 1, 0);
    chk("R9 sealed config still running", {31'b0, wdt_rst}, 32'h1);
    do_reset();
    chk("R9 reset unseals", rd_data, 32'h0001_0080);
    keyed(32'h0001_0301);
    chk("R9 writable after reset", rd_data, 32'h0001_0301);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule